// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Window

This block lets a host reach a large internal word memory and a separate peripheral register space through a handful of directly addressed window registers. The host first loads a pointer register and then touches the matching data port. Every touch of a memory data port moves one 32-bit word over a single internal request/acknowledge port and steps the pointer that was used by four bytes. Reads and writes keep separate pointers, so a stream of reads and a stream of writes can be interleaved without either one disturbing the other.

Peripheral accesses use their own read and write address registers. Each holds a 16-bit register offset together with a two-bit size field that gives the number of bytes minus one. The size field drives the byte enables of the internal request, and it trims the returned read data. Peripheral addresses never advance. Any host access to a data port waits until the internal side acknowledges, so internal latency shows up as a stretched host handshake.

Top module: `indirect_window`

## Requirements
- R1: After synchronous reset, both memory pointers and both peripheral address registers read back as zero, `host_ready` is low and no internal request is issued.
- R2: A host write to the memory write port stores the word at the current write pointer and then advances that pointer by 4.
- R3: A host read of the memory read port returns the word at the current read pointer and then advances that pointer by 4.
- R4: A memory read leaves the write pointer unchanged, and a memory write leaves the read pointer unchanged.
- R5: The memory pointers are 32 bits wide and wrap from 0xFFFFFFFC to 0x00000000.
- R6: For a data-port access, `host_ready` stays low until `int_ack` has been seen. `host_ready` is a single-cycle pulse, and only one internal request is outstanding at any time.
- R7: A peripheral address register keeps only bits [15:0] (offset) and bits [25:24] (size = byte count minus one). All other bits read back as zero.
- R8: A peripheral write drives byte enables for the low size+1 bytes only (size 0 gives 4'b0001, size 3 gives 4'b1111).
- R9: Peripheral read data returns the low size+1 bytes of the internal word, and the bytes above them read as zero.
- R10: Peripheral address registers do not change after a peripheral data access.
- R11: A read of either write port returns zero and starts no internal access. A write to either read port is ignored, and neither case moves any pointer.
- R12: Memory requests always carry byte enables 4'b1111. Peripheral requests carry `int_space`=1 and zeros in address bits [31:16].
- R13: `host_sel` encoding: 0 memory read pointer, 1 memory write pointer, 2 memory write port, 3 memory read port, 4 peripheral read address, 5 peripheral write address, 6 peripheral write port, 7 peripheral read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request, held until `host_ready` |
| host_write | input | 1 | 1 = write, 0 = read |
| host_sel | input | 3 | Window register select (R13) |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with `host_ready` |
| int_req | output | 1 | One-cycle internal request pulse |
| int_space | output | 1 | 0 = memory, 1 = peripheral |
| int_we | output | 1 | Internal write |
| int_addr | output | 32 | Internal byte address |
| int_be | output | 4 | Internal byte enables |
| int_wdata | output | 32 | Internal write data |
| int_ack | input | 1 | Internal completion, one cycle |
| int_rdata | input | 32 | Internal read data, valid with `int_ack` |

## Verification
The hardest case to reach is pointer wrap at the top of the 32-bit space, combined with interleaving. To get there, a pointer has to be parked at 0xFFFFFFFC, an access has to complete through a slow acknowledge, and the other pointer has to be shown untouched. The stimulus first runs interleaved reads and writes over overlapping addresses. It then loads both pointers with the last dword and reads back the word it just wrote there, along with both pointers. A bench responder with several cycles of acknowledge latency keeps every data access stalled, so the stepping and trimming are observed only after real waits.

// File: rtl/iw_pkg.sv
package iw_pkg;

    localparam int WORD_W       = 32;
    localparam int BE_W         = WORD_W / 8;
    localparam int WIN_ADDR_W   = 32;
    localparam int SEL_W        = 3;
    localparam int PER_OFFS_W   = 16;
    localparam int PER_SIZE_W   = 2;
    localparam int PER_SIZE_LSB = 24;
    localparam int PTR_STEP     = BE_W;
    localparam int N_MEM_PTR    = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_MEM_RPTR  = 3'd0,
        SEL_MEM_WPTR  = 3'd1,
        SEL_MEM_WPORT = 3'd2,
        SEL_MEM_RPORT = 3'd3,
        SEL_PER_RADDR = 3'd4,
        SEL_PER_WADDR = 3'd5,
        SEL_PER_WPORT = 3'd6,
        SEL_PER_RPORT = 3'd7
    } win_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } xfer_st_e;

    typedef struct packed {
        logic [PER_SIZE_W-1:0] size;
        logic [PER_OFFS_W-1:0] offs;
    } per_addr_t;

    typedef struct packed {
        logic                  space;
        logic                  we;
        logic [WIN_ADDR_W-1:0] addr;
        logic [BE_W-1:0]       be;
        logic [WORD_W-1:0]     wdata;
    } int_cmd_t;

    // select bit 1 marks a data port, bit 2 the peripheral space
    function automatic logic sel_is_port(input win_sel_e s);
        return s[1];
    endfunction

    function automatic logic sel_space(input win_sel_e s);
        return s[2];
    endfunction

    // a port is usable only in its own direction: bit 0 clear = write port
    function automatic logic sel_dir_ok(input win_sel_e s, input logic wr);
        return (s[0] == 1'b0) ? wr : !wr;
    endfunction

    function automatic logic [BE_W-1:0] size_be(input logic [PER_SIZE_W-1:0] sz);
        logic [BE_W-1:0] be;
        for (int i = 0; i < BE_W; i++) be[i] = (i <= int'(sz));
        return be;
    endfunction

    function automatic logic [WORD_W-1:0] keep_bytes(input logic [WORD_W-1:0] d,
                                                     input logic [BE_W-1:0] be);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < BE_W; i++) r[8*i +: 8] = be[i] ? d[8*i +: 8] : 8'h00;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] per_view(input per_addr_t a);
        logic [WORD_W-1:0] r;
        r = '0;
        r[PER_OFFS_W-1:0] = a.offs;
        r[PER_SIZE_LSB +: PER_SIZE_W] = a.size;
        return r;
    endfunction

endpackage

// File: rtl/iw_ptr_bank.sv
module iw_ptr_bank
    import iw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  win_sel_e              cfg_sel,
    input  logic [WORD_W-1:0]     cfg_wdata,
    input  logic                  bump_rd,
    input  logic                  bump_wr,
    output logic [WIN_ADDR_W-1:0] mem_rptr,
    output logic [WIN_ADDR_W-1:0] mem_wptr,
    output per_addr_t             per_raddr,
    output per_addr_t             per_waddr
);

    logic [WIN_ADDR_W-1:0] mptr [N_MEM_PTR];
    per_addr_t             preg [N_MEM_PTR];

    // index 0 serves reads, index 1 serves writes
    for (genvar g = 0; g < N_MEM_PTR; g++) begin : g_ptr
        localparam win_sel_e MEM_SEL = (g == 0) ? SEL_MEM_RPTR  : SEL_MEM_WPTR;
        localparam win_sel_e PER_SEL = (g == 0) ? SEL_PER_RADDR : SEL_PER_WADDR;
        logic bump;
        assign bump = (g == 0) ? bump_rd : bump_wr;

        always_ff @(posedge clk) begin
            if (rst) begin
                mptr[g] <= '0;
            end else if (cfg_we && cfg_sel == MEM_SEL) begin
                mptr[g] <= cfg_wdata[WIN_ADDR_W-1:0];
            end else if (bump) begin
                mptr[g] <= mptr[g] + WIN_ADDR_W'(PTR_STEP);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                preg[g] <= '0;
            end else if (cfg_we && cfg_sel == PER_SEL) begin
                preg[g].offs <= cfg_wdata[PER_OFFS_W-1:0];
                preg[g].size <= cfg_wdata[PER_SIZE_LSB +: PER_SIZE_W];
            end
        end
    end

    assign mem_rptr  = mptr[0];
    assign mem_wptr  = mptr[1];
    assign per_raddr = preg[0];
    assign per_waddr = preg[1];

    // R4: the two pointers never step in the same cycle
    assert_one_bump_R4: assert property (@(posedge clk) disable iff (rst)
        !(bump_rd && bump_wr));

endmodule

// File: rtl/iw_xfer_fsm.sv
module iw_xfer_fsm
    import iw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_valid,
    input  logic                  host_write,
    input  win_sel_e              host_sel,
    input  logic [WORD_W-1:0]     host_wdata,
    input  logic [WORD_W-1:0]     reg_view,
    input  logic [WIN_ADDR_W-1:0] mem_rptr,
    input  logic [WIN_ADDR_W-1:0] mem_wptr,
    input  per_addr_t             per_raddr,
    input  per_addr_t             per_waddr,
    output logic                  cfg_we,
    output logic                  bump_rd,
    output logic                  bump_wr,
    output logic                  host_ready,
    output logic [WORD_W-1:0]     host_rdata,
    output logic                  int_req,
    output int_cmd_t              int_cmd,
    input  logic                  int_ack,
    input  logic [WORD_W-1:0]     int_rdata
);

    xfer_st_e          st;
    int_cmd_t          cmd_q;
    int_cmd_t          cmd_d;
    logic              req_q;
    logic [WORD_W-1:0] rdata_q;
    logic              is_port;
    logic              go_xfer;
    per_addr_t         per_sel;

    assign is_port = sel_is_port(host_sel);
    assign go_xfer = is_port && sel_dir_ok(host_sel, host_write);
    assign per_sel = host_write ? per_waddr : per_raddr;

    always_comb begin
        cmd_d       = '0;
        cmd_d.space = sel_space(host_sel);
        cmd_d.we    = host_write;
        cmd_d.wdata = host_wdata;
        if (cmd_d.space) begin
            cmd_d.addr = WIN_ADDR_W'(per_sel.offs);
            cmd_d.be   = size_be(per_sel.size);
        end else begin
            cmd_d.addr = host_write ? mem_wptr : mem_rptr;
            cmd_d.be   = '1;
        end
    end

    assign cfg_we  = (st == ST_IDLE) && host_valid && host_write && !is_port;
    assign bump_rd = (st == ST_WAIT) && int_ack && !cmd_q.space && !cmd_q.we;
    assign bump_wr = (st == ST_WAIT) && int_ack && !cmd_q.space && cmd_q.we;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cmd_q   <= '0;
            req_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (host_valid) begin
                        if (go_xfer) begin
                            cmd_q <= cmd_d;
                            req_q <= 1'b1;
                            st    <= ST_WAIT;
                        end else begin
                            rdata_q <= (host_write || is_port) ? '0 : reg_view;
                            st      <= ST_RESP;
                        end
                    end
                end
                ST_WAIT: begin
                    req_q <= 1'b0;
                    if (int_ack) begin
                        if (cmd_q.we)         rdata_q <= '0;
                        else if (cmd_q.space) rdata_q <= keep_bytes(int_rdata, cmd_q.be);
                        else                  rdata_q <= int_rdata;
                        st <= ST_RESP;
                    end
                end
                ST_RESP: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign host_ready = (st == ST_RESP);
    assign host_rdata = rdata_q;
    assign int_req    = req_q;
    assign int_cmd    = cmd_q;

    assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        int_req |=> !int_req);
    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);
    assert_no_req_while_ready_R6: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> !int_req);
    assert_cmd_held_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && !int_ack) |=> $stable(int_cmd));
    assert_mem_be_R12: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_cmd.space) |-> (int_cmd.be == '1));
    assert_per_addr_R12: assert property (@(posedge clk) disable iff (rst)
        (int_req && int_cmd.space) |-> (int_cmd.addr[WIN_ADDR_W-1:PER_OFFS_W] == '0 && int_cmd.be[0]));

endmodule

// File: rtl/indirect_window.sv
module indirect_window
    import iw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_valid,
    input  logic                  host_write,
    input  logic [SEL_W-1:0]      host_sel,
    input  logic [WORD_W-1:0]     host_wdata,
    output logic                  host_ready,
    output logic [WORD_W-1:0]     host_rdata,
    output logic                  int_req,
    output logic                  int_space,
    output logic                  int_we,
    output logic [WIN_ADDR_W-1:0] int_addr,
    output logic [BE_W-1:0]       int_be,
    output logic [WORD_W-1:0]     int_wdata,
    input  logic                  int_ack,
    input  logic [WORD_W-1:0]     int_rdata
);

    win_sel_e              sel;
    logic                  cfg_we;
    logic                  bump_rd;
    logic                  bump_wr;
    logic [WIN_ADDR_W-1:0] mem_rptr;
    logic [WIN_ADDR_W-1:0] mem_wptr;
    per_addr_t             per_raddr;
    per_addr_t             per_waddr;
    logic [WORD_W-1:0]     reg_view;
    int_cmd_t              cmd;

    assign sel = win_sel_e'(host_sel);

    always_comb begin
        case (sel)
            SEL_MEM_RPTR:  reg_view = WORD_W'(mem_rptr);
            SEL_MEM_WPTR:  reg_view = WORD_W'(mem_wptr);
            SEL_PER_RADDR: reg_view = per_view(per_raddr);
            SEL_PER_WADDR: reg_view = per_view(per_waddr);
            default:       reg_view = '0;
        endcase
    end

    iw_ptr_bank u_ptr (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (sel),
        .cfg_wdata (host_wdata),
        .bump_rd   (bump_rd),
        .bump_wr   (bump_wr),
        .mem_rptr  (mem_rptr),
        .mem_wptr  (mem_wptr),
        .per_raddr (per_raddr),
        .per_waddr (per_waddr)
    );

    iw_xfer_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_sel   (sel),
        .host_wdata (host_wdata),
        .reg_view   (reg_view),
        .mem_rptr   (mem_rptr),
        .mem_wptr   (mem_wptr),
        .per_raddr  (per_raddr),
        .per_waddr  (per_waddr),
        .cfg_we     (cfg_we),
        .bump_rd    (bump_rd),
        .bump_wr    (bump_wr),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .int_req    (int_req),
        .int_cmd    (cmd),
        .int_ack    (int_ack),
        .int_rdata  (int_rdata)
    );

    assign int_space = cmd.space;
    assign int_we    = cmd.we;
    assign int_addr  = cmd.addr;
    assign int_be    = cmd.be;
    assign int_wdata = cmd.wdata;

    assert_rd_step_R3: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_space && !int_we) |=> (mem_rptr == $past(mem_rptr) + WIN_ADDR_W'(PTR_STEP)));
    assert_wr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_space && int_we) |=> (mem_wptr == $past(mem_wptr) + WIN_ADDR_W'(PTR_STEP)));
    assert_wr_indep_R4: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_space && !int_we) |=> $stable(mem_wptr));
    assert_rd_indep_R4: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_space && int_we) |=> $stable(mem_rptr));
    assert_per_fixed_R10: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_space) |=> ($stable(per_raddr) && $stable(per_waddr)));
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!int_req && !host_ready && mem_rptr == '0 && mem_wptr == '0));

endmodule

// File: tb/indirect_window_bench.sv
module indirect_window_bench;

    localparam int LAT   = 3;
    localparam int NVEC  = 37;
    localparam int WD_LIM = 1000;

    typedef struct packed {
        logic [2:0]  sel;
        logic        wr;
        logic [31:0] data;
        logic [31:0] expv;
        logic        chk;
        logic [3:0]  req;
    } vec_t;

    // R13 select map: 0 rptr, 1 wptr, 2 mem wport, 3 mem rport,
    // 4 per raddr, 5 per waddr, 6 per wport, 7 per rport
    localparam vec_t VECS [NVEC] = '{
        '{3'd1, 1'b1, 32'h0000_0100, 32'h0, 1'b0, 4'd2},
        '{3'd2, 1'b1, 32'hA0A0_A001, 32'h0, 1'b0, 4'd2},
        '{3'd2, 1'b1, 32'hA0A0_A002, 32'h0, 1'b0, 4'd2},
        '{3'd1, 1'b0, 32'h0, 32'h0000_0108, 1'b1, 4'd2},   // R2 step
        '{3'd0, 1'b1, 32'h0000_00F8, 32'h0, 1'b0, 4'd3},
        '{3'd3, 1'b0, 32'h0, 32'hC0DE_003E, 1'b1, 4'd3},   // R3
        '{3'd3, 1'b0, 32'h0, 32'hC0DE_003F, 1'b1, 4'd3},
        '{3'd3, 1'b0, 32'h0, 32'hA0A0_A001, 1'b1, 4'd2},
        '{3'd2, 1'b1, 32'hA0A0_A003, 32'h0, 1'b0, 4'd4},
        '{3'd3, 1'b0, 32'h0, 32'hA0A0_A002, 1'b1, 4'd4},   // R4 interleave
        '{3'd0, 1'b0, 32'h0, 32'h0000_0108, 1'b1, 4'd4},
        '{3'd1, 1'b0, 32'h0, 32'h0000_010C, 1'b1, 4'd4},
        '{3'd3, 1'b0, 32'h0, 32'hA0A0_A003, 1'b1, 4'd4},
        '{3'd2, 1'b0, 32'h0, 32'h0, 1'b1, 4'd11},          // R11 read of wport
        '{3'd1, 1'b0, 32'h0, 32'h0000_010C, 1'b1, 4'd11},
        '{3'd3, 1'b1, 32'hDEAD_0000, 32'h0, 1'b0, 4'd11},
        '{3'd0, 1'b0, 32'h0, 32'h0000_010C, 1'b1, 4'd11},
        '{3'd5, 1'b1, 32'h0100_0010, 32'h0, 1'b0, 4'd8},
        '{3'd6, 1'b1, 32'hAABB_CCDD, 32'h0, 1'b0, 4'd8},
        '{3'd5, 1'b0, 32'h0, 32'h0100_0010, 1'b1, 4'd10},  // R10
        '{3'd4, 1'b1, 32'h0300_0010, 32'h0, 1'b0, 4'd8},
        '{3'd7, 1'b0, 32'h0, 32'h1111_CCDD, 1'b1, 4'd8},   // R8 two bytes written
        '{3'd7, 1'b0, 32'h0, 32'h1111_CCDD, 1'b1, 4'd10},
        '{3'd4, 1'b1, 32'h0000_0010, 32'h0, 1'b0, 4'd9},
        '{3'd7, 1'b0, 32'h0, 32'h0000_00DD, 1'b1, 4'd9},   // R9
        '{3'd4, 1'b1, 32'h0200_0010, 32'h0, 1'b0, 4'd9},
        '{3'd7, 1'b0, 32'h0, 32'h0011_CCDD, 1'b1, 4'd9},
        '{3'd5, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd7},
        '{3'd5, 1'b0, 32'h0, 32'h0300_FFFF, 1'b1, 4'd7},   // R7
        '{3'd4, 1'b0, 32'h0, 32'h0200_0010, 1'b1, 4'd7},
        '{3'd1, 1'b1, 32'hFFFF_FFFC, 32'h0, 1'b0, 4'd5},
        '{3'd2, 1'b1, 32'h5A5A_5A5A, 32'h0, 1'b0, 4'd5},
        '{3'd1, 1'b0, 32'h0, 32'h0000_0000, 1'b1, 4'd5},   // R5 wrap
        '{3'd0, 1'b1, 32'hFFFF_FFFC, 32'h0, 1'b0, 4'd5},
        '{3'd3, 1'b0, 32'h0, 32'h5A5A_5A5A, 1'b1, 4'd5},
        '{3'd0, 1'b0, 32'h0, 32'h0000_0000, 1'b1, 4'd5},
        '{3'd6, 1'b0, 32'h0, 32'h0, 1'b1, 4'd11}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [31:0] host_wdata = 32'h0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        int_req, int_space, int_we;
    logic [31:0] int_addr, int_wdata;
    logic [3:0]  int_be;
    logic        int_ack = 1'b0;
    logic [31:0] int_rdata = 32'h0;

    int n_chk = 0;
    int n_fail = 0;
    int bad12 = 0;

    always #10ns clk = ~clk;

    indirect_window u_indirect_window (
        .clk(clk), .rst(rst),
        .host_valid(host_valid), .host_write(host_write), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
        .int_req(int_req), .int_space(int_space), .int_we(int_we), .int_addr(int_addr),
        .int_be(int_be), .int_wdata(int_wdata), .int_ack(int_ack), .int_rdata(int_rdata)
    );

    // responder with fixed latency
    logic [31:0] bmem [256];
    logic [31:0] pmem [16];
    logic        pend = 1'b0;
    int          cnt = 0;
    logic        c_space, c_we;
    logic [31:0] c_addr, c_wdata;
    logic [3:0]  c_be;

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 32'hC0DE_0000 | i;
        for (int i = 0; i < 16; i++)  pmem[i] = 32'h1111_1111;
    end

    always @(posedge clk) begin
        int_ack <= 1'b0;
        if (int_req) begin
            pend <= 1'b1; cnt <= LAT;
            c_space <= int_space; c_we <= int_we; c_addr <= int_addr;
            c_wdata <= int_wdata; c_be <= int_be;
            if ((!int_space && int_be != 4'hF) || (int_space && int_addr[31:16] != 16'h0))
                bad12 <= bad12 + 1;
        end else if (pend) begin
            if (cnt == 1) begin
                pend <= 1'b0;
                int_ack <= 1'b1;
                if (c_space) begin
                    if (c_we) begin
                        for (int b = 0; b < 4; b++)
                            if (c_be[b]) pmem[c_addr[5:2]][8*b +: 8] <= c_wdata[8*b +: 8];
                    end
                    int_rdata <= pmem[c_addr[5:2]];
                end else begin
                    if (c_we) bmem[c_addr[9:2]] <= c_wdata;
                    int_rdata <= bmem[c_addr[9:2]];
                end
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp_v);
        end
    endtask

    task automatic acc(input logic [2:0] s, input logic w, input logic [31:0] d,
                       output logic [31:0] rd, output int cyc);
        @(negedge clk);
        host_valid = 1'b1; host_sel = s; host_write = w; host_wdata = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!host_ready && cyc < WD_LIM);
        if (!host_ready) begin
            n_chk++; n_fail++;
            $display("FAIL R6: watchdog, actual no ready expected ready");
        end
        rd = host_rdata;
        host_valid = 1'b0;
    endtask

    initial begin
        #(20ns * 150000);
        n_chk++; n_fail++;
        $display("FAIL R6: global watchdog, actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 ready low", {31'h0, host_ready}, 32'h0);
        check("R1 no req", {31'h0, int_req}, 32'h0);
        acc(3'd0, 1'b0, 0, rd, cyc); check("R1 rptr", rd, 32'h0);
        acc(3'd1, 1'b0, 0, rd, cyc); check("R1 wptr", rd, 32'h0);
        acc(3'd4, 1'b0, 0, rd, cyc); check("R1 per raddr", rd, 32'h0);
        acc(3'd5, 1'b0, 0, rd, cyc); check("R1 per waddr", rd, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            acc(VECS[i].sel, VECS[i].wr, VECS[i].data, rd, cyc);
            if (VECS[i].chk) begin
                n_chk++;
                if (rd !== VECS[i].expv) begin
                    n_fail++;
                    $display("FAIL R%0d: vector %0d actual %08h expected %08h",
                             VECS[i].req, i, rd, VECS[i].expv);
                end
            end
        end

        // R6 stall: data access completes only after the slow acknowledge
        acc(3'd0, 1'b1, 32'h0000_0100, rd, cyc);
        check("R6 register access one cycle", cyc, 32'd1);
        acc(3'd3, 1'b0, 0, rd, cyc);
        check("R6 stalled data", rd, 32'hA0A0_A001);
        check("R6 stall length", (cyc > LAT) ? 32'd1 : 32'd0, 32'd1);

        // R12 internal port encoding
        check("R12 request fields", bad12, 32'd0);

        // R1 reset in mid operation clears the pointer
        acc(3'd0, 1'b1, 32'h0000_0040, rd, cyc);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        acc(3'd0, 1'b0, 0, rd, cyc); check("R1 rptr after reset", rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule